// File: doc/BRIEF.md
# SPI Master with Contention Fault Guard

This block is a byte-oriented SPI master driven through a small register bus. Software selects master operation and timing in a mode register, enables the engine through a control register, and writes a byte together with a target chip-select number into the transmit register. The engine asserts the selected chip select, shifts the byte out MSB first on `mosi` while shifting `miso` in, and places the received byte in the receive register. Status bits report when transmit space is free, when a received byte is waiting, whether the engine is enabled or busy, and whether a fault occurred.

Chip-select handling is programmable. A keep bit holds the last chip select low across frames to the same target, and a separate delay sets how long all selects stay high before a new one is driven low. A second delay sets the minimum gap between frames.

The `nss_in` pin is watched for another master driving the bus. When the engine is enabled in master mode and this input is seen low, the block raises a sticky fault flag. It then aborts any frame, releases every chip select and returns the clock to idle. It also disables itself until software enables it again.

Top module: `spi_fault_master`

## Requirements
- R1: After reset all `cs_n` bits are high, `sclk` is low, the mode register (address 1) reads 0 and the status register (address 4) reads 0x02: only tx_empty (bit 1) is set, with rx_full bit 0, fault bit 2, enabled bit 3 and busy bit 4 all clear.
- R2: A frame is 8 bits, MSB first. `mosi` is valid before each leading clock edge, `miso` is sampled on the leading edge, and the received byte reads back from address 3 bits [7:0]. Mode bit 3 sets the idle level of `sclk`. Writing address 0 bit 0 enables the engine. Mode bit 0 selects master operation.
- R3: Writing address 2 (data in bits [7:0], target select in bits [17:16]) clears tx_empty, and tx_empty sets again once the shifter has taken the byte.
- R4: rx_full sets when a frame completes and clears when address 3 is read.
- R5: With mode bit 2 (keep) clear, the chip select goes high at the end of every frame. At most one `cs_n` bit is ever low, and `sclk` sits at its idle level whenever all chip selects are high.
- R6: With keep set, the chip select stays low between frames to the same target.
- R7: Before a chip select is driven low for a different target (or from all-high), all chip selects stay high for max(1, mode[23:16]) clock cycles.
- R8: Between the last trailing clock edge of one frame and the first leading edge of the next there are at least max(1, mode[15:8]) clock cycles.
- R9: With the engine enabled, master mode on and mode bit 1 clear, a low on `nss_in` (after a two-flop synchronizer) sets the fault flag, clears enabled, aborts the frame, drives all `cs_n` high, returns `sclk` to idle and drops a pending transmit byte.
- R10: The fault flag stays set until the status register is read. The engine stays disabled, and does not start a written byte, until address 0 bit 0 is written with 1.
- R11: A low `nss_in` raises no fault while mode bit 1 is set or master mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid combinationally while reg_en is high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low peripheral chip selects |
| nss_in | input | 1 | Contention sense input, low = another master present |

## Verification
A slave model returns its own byte while capturing `mosi`. It is driven with complementary, all-ones/all-zeros and alternating patterns on different targets, so that a bit-order, sampling-edge or select-decode error shows up as a mismatched byte or a wrong `cs_n` bit. Back-to-back frames with keep on show the hold behaviour and the inter-frame gap, and a switch of target shows the all-high interval. A pulled-down `nss_in` is tried mid-frame and also with detection masked and with master mode off, which separates a real fault from a spurious one.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned FRAME_W = 8;
    localparam int unsigned DLY_W   = 8;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_MODE = 3'd1;
    localparam logic [2:0] ADR_TX   = 3'd2;
    localparam logic [2:0] ADR_RX   = 3'd3;
    localparam logic [2:0] ADR_STAT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CSWAIT = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_GAP    = 2'd3
    } spim_state_e;

endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(HALF - 1));

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_fault_master.sv
module spi_fault_master
    import spim_pkg::*;
#(
    parameter int unsigned NUM_CS      = 4,
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BUS_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    input  logic              nss_in
);
    localparam int unsigned CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int unsigned EDGES = 2 * FRAME_W;
    localparam int unsigned ECW   = $clog2(EDGES);
    localparam int unsigned TX_CS_LSB = 16;

    typedef struct packed {
        spim_state_e        state;
        logic               en;
        logic               master;
        logic               fdis;
        logic               keep;
        logic               cpol;
        logic [DLY_W-1:0]   gap_dly;
        logic [DLY_W-1:0]   cs_dly;
        logic [FRAME_W-1:0] tx_data;
        logic [CSW-1:0]     tx_cs;
        logic               tx_empty;
        logic [FRAME_W-1:0] rx_data;
        logic               rx_full;
        logic               fault;
        logic [FRAME_W-1:0] sh_out;
        logic [FRAME_W-1:0] sh_in;
        logic [ECW-1:0]     edge_cnt;
        logic [DLY_W-1:0]   dly_cnt;
        logic               cs_on;
        logic [CSW-1:0]     cs_cur;
    } spim_regs_t;

    spim_regs_t q, n;

    logic nss_s;
    logic tick;

    spim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nss_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nss_in),
        .q     (nss_s)
    );

    spim_tick #(.HALF(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.state == ST_SHIFT),
        .tick  (tick)
    );

    logic rd_stat, rd_rx, wr_ctrl, wr_mode, wr_tx, fault_evt;

    assign rd_stat   = reg_en && !reg_wr && (reg_addr == ADR_STAT);
    assign rd_rx     = reg_en && !reg_wr && (reg_addr == ADR_RX);
    assign wr_ctrl   = reg_en &&  reg_wr && (reg_addr == ADR_CTRL);
    assign wr_mode   = reg_en &&  reg_wr && (reg_addr == ADR_MODE);
    assign wr_tx     = reg_en &&  reg_wr && (reg_addr == ADR_TX);
    assign fault_evt = q.en && q.master && !q.fdis && !nss_s;

    function automatic logic [DLY_W-1:0] min1(input logic [DLY_W-1:0] v);
        return (v == '0) ? DLY_W'(1) : v;
    endfunction

    always_comb begin
        n = q;

        // read side effects first, so a set in the same cycle wins
        if (rd_stat) n.fault   = 1'b0;
        if (rd_rx)   n.rx_full = 1'b0;

        if (!q.en || !q.master) begin
            n.state    = ST_IDLE;
            n.cs_on    = 1'b0;
            n.edge_cnt = '0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (!q.tx_empty) begin
                        n.sh_out   = q.tx_data;
                        n.tx_empty = 1'b1;
                        n.edge_cnt = '0;
                        if (q.cs_on && (q.cs_cur == q.tx_cs)) begin
                            n.state = ST_SHIFT;
                        end else begin
                            n.cs_on   = 1'b0;
                            n.cs_cur  = q.tx_cs;
                            n.dly_cnt = min1(q.cs_dly);
                            n.state   = ST_CSWAIT;
                        end
                    end
                end
                ST_CSWAIT: begin
                    if (q.dly_cnt == DLY_W'(1)) begin
                        n.cs_on = 1'b1;
                        n.state = ST_SHIFT;
                    end else begin
                        n.dly_cnt = q.dly_cnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        n.edge_cnt = q.edge_cnt + 1'b1;
                        if (!q.edge_cnt[0]) begin
                            n.sh_in = {q.sh_in[FRAME_W-2:0], miso};
                        end else begin
                            n.sh_out = {q.sh_out[FRAME_W-2:0], 1'b0};
                            if (q.edge_cnt == ECW'(EDGES - 1)) begin
                                n.rx_data  = q.sh_in;
                                n.rx_full  = 1'b1;
                                n.edge_cnt = '0;
                                n.dly_cnt  = min1(q.gap_dly);
                                n.state    = ST_GAP;
                                if (!q.keep) n.cs_on = 1'b0;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (q.dly_cnt == DLY_W'(1)) n.state = ST_IDLE;
                    else                        n.dly_cnt = q.dly_cnt - 1'b1;
                end
                default: n.state = ST_IDLE;
            endcase
        end

        // register writes
        if (wr_ctrl) begin
            if (reg_wdata[0]) n.en = 1'b1;
            if (reg_wdata[1]) n.en = 1'b0;
        end
        if (wr_mode) begin
            n.master  = reg_wdata[0];
            n.fdis    = reg_wdata[1];
            n.keep    = reg_wdata[2];
            n.cpol    = reg_wdata[3];
            n.gap_dly = reg_wdata[8 +: DLY_W];
            n.cs_dly  = reg_wdata[16 +: DLY_W];
        end
        if (wr_tx) begin
            n.tx_data  = reg_wdata[FRAME_W-1:0];
            n.tx_cs    = reg_wdata[TX_CS_LSB +: CSW];
            n.tx_empty = 1'b0;
        end

        // contention fault overrides everything
        if (fault_evt) begin
            n.fault    = 1'b1;
            n.en       = 1'b0;
            n.state    = ST_IDLE;
            n.cs_on    = 1'b0;
            n.edge_cnt = '0;
            n.tx_empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.tx_empty <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign sclk = q.cpol ^ ((q.state == ST_SHIFT) && q.edge_cnt[0]);
    assign mosi = q.sh_out[FRAME_W-1];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(q.cs_on && (q.cs_cur == CSW'(i)));
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_MODE: begin
                reg_rdata[0]            = q.master;
                reg_rdata[1]            = q.fdis;
                reg_rdata[2]            = q.keep;
                reg_rdata[3]            = q.cpol;
                reg_rdata[8 +: DLY_W]   = q.gap_dly;
                reg_rdata[16 +: DLY_W]  = q.cs_dly;
            end
            ADR_RX:   reg_rdata[FRAME_W-1:0] = q.rx_data;
            ADR_STAT: begin
                reg_rdata[0] = q.rx_full;
                reg_rdata[1] = q.tx_empty;
                reg_rdata[2] = q.fault;
                reg_rdata[3] = q.en;
                reg_rdata[4] = (q.state != ST_IDLE);
            end
            default: reg_rdata = '0;
        endcase
    end

    // plain views of state for the bound checker
    logic cpol_q, en_q, fault_q, fdis_q, tx_empty_q;
    assign cpol_q     = q.cpol;
    assign en_q       = q.en;
    assign fault_q    = q.fault;
    assign fdis_q     = q.fdis;
    assign tx_empty_q = q.tx_empty;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int unsigned NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              cpol_q,
    input logic              en_q,
    input logic              fault_q,
    input logic              fdis_q,
    input logic              tx_empty_q
);
    logic stat_read, tx_write;
    assign stat_read = reg_en && !reg_wr && (reg_addr == 3'd4);
    assign tx_write  = reg_en &&  reg_wr && (reg_addr == 3'd2);

    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (sclk == cpol_q));

    p_tx_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !tx_empty_q);

    p_fault_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> ((&cs_n) && !en_q));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !stat_read) |=> fault_q);

    p_fault_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fdis_q && !fault_q) |=> !fault_q);
endmodule

bind spi_fault_master spim_checker #(.NUM_CS(NUM_CS)) u_spim_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .cpol_q     (cpol_q),
    .en_q       (en_q),
    .fault_q    (fault_q),
    .fdis_q     (fdis_q),
    .tx_empty_q (tx_empty_q)
);

// File: tb/tb_spi_fault_master.sv
`timescale 1ns/1ps
module tb_spi_fault_master;
    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [NCS-1:0] cs_n;
    logic        nss_in = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_fault_master dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .nss_in(nss_in)
    );

    // ---------------- slave model ----------------
    logic [7:0] s_tx = 8'h00;
    logic [7:0] s_shift = 8'h00;
    logic [7:0] cap = 8'h00;
    logic       tb_cpol = 1'b0;
    logic       sclk_prev = 1'b0;
    int         bits = 0;
    assign miso = s_shift[7];

    always @(cs_n or sclk or s_tx) begin
        if (&cs_n) begin
            bits    = 0;
            s_shift = s_tx;
        end else if (sclk !== sclk_prev) begin
            if (sclk != tb_cpol) begin
                cap  = {cap[6:0], mosi};
                bits = bits + 1;
            end else if (bits == 8) begin
                bits    = 0;
                s_shift = s_tx;
            end else begin
                s_shift = {s_shift[6:0], 1'b0};
            end
        end
        sclk_prev = sclk;
    end

    // ---------------- monitors ----------------
    int hi_run = 0, last_hi_run = 0, hi_total = 0;
    int since_fall = 0, last_long = 0;
    logic mon_sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (&cs_n) begin
            hi_run   = hi_run + 1;
            hi_total = hi_total + 1;
        end else if (hi_run != 0) begin
            last_hi_run = hi_run;
            hi_run      = 0;
        end
        if (sclk && !mon_sclk_prev && since_fall > 4) last_long = since_fall;
        if (!sclk && mon_sclk_prev) since_fall = 1;
        else                        since_fall = since_fall + 1;
        mon_sclk_prev = sclk;
    end

    initial begin
        #(5.0 * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(3'd4, s);
            if (!s[4] && s[1]) return;
        end
    endtask

    task automatic send(input int cs, input logic [7:0] d, input logic [7:0] stx);
        s_tx = stx;
        bus_wr(3'd2, (32'(cs) << 16) | 32'(d));
    endtask

    localparam logic [31:0] MODE_BASE = 32'h0003_0201; // master, gap 2, cs delay 3

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        chk(cs_n == 4'hF, "R1", "cs_n after reset", 32'(cs_n), 32'hF);
        chk(sclk == 1'b0, "R1", "sclk after reset", 32'(sclk), 0);
        bus_rd(3'd4, v);
        chk(v == 32'h2, "R1", "status after reset", v, 32'h2);
        bus_rd(3'd1, v);
        chk(v == 32'h0, "R1", "mode after reset", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        logic [7:0] txp [3] = '{8'hA5, 8'hFF, 8'h55};
        logic [7:0] rxp [3] = '{8'h3C, 8'h00, 8'hAA};
        int         csp [3] = '{1, 3, 0};
        bus_wr(3'd1, MODE_BASE);
        bus_wr(3'd0, 32'h1);
        for (int k = 0; k < 3; k++) begin
            send(csp[k], txp[k], rxp[k]);
            bus_rd(3'd4, v);
            chk(v[1] == 1'b0, "R3", "tx_empty right after write", 32'(v[1]), 0);
            bus_rd(3'd4, v);
            chk(v[1] == 1'b1, "R3", "tx_empty after load", 32'(v[1]), 1);
            idle_cycles(6);
            chk(cs_n == ~(4'b1 << csp[k]), "R5", "selected cs mid frame", 32'(cs_n), 32'(~(4'b1 << csp[k]) & 4'hF));
            wait_idle();
            chk(cap == txp[k], "R2", "mosi byte", 32'(cap), 32'(txp[k]));
            chk(cs_n == 4'hF, "R5", "cs released after frame", 32'(cs_n), 32'hF);
            bus_rd(3'd4, v);
            chk(v[0] == 1'b1, "R4", "rx_full after frame", 32'(v[0]), 1);
            bus_rd(3'd3, v);
            chk(v[7:0] == rxp[k], "R2", "received byte", 32'(v[7:0]), 32'(rxp[k]));
            bus_rd(3'd4, v);
            chk(v[0] == 1'b0, "R4", "rx_full after rx read", 32'(v[0]), 0);
        end
    endtask

    task automatic t_hold_gap_switch();
        logic [31:0] v;
        int hi_snap;
        // keep on, gap 20, cs delay 10
        bus_wr(3'd1, 32'h000A_1405);
        send(2, 8'h12, 8'h00);
        for (int i = 0; i < 50; i++) begin
            bus_rd(3'd4, v);
            if (v[1]) break;
        end
        idle_cycles(12);
        hi_snap = hi_total;
        send(2, 8'h34, 8'h00);
        wait_idle();
        chk(cs_n == 4'b1011, "R6", "cs held after frames", 32'(cs_n), 32'hB);
        chk(hi_total == hi_snap, "R6", "no release between frames", 32'(hi_total - hi_snap), 0);
        chk(last_long >= 20 && last_long <= 26, "R8", "inter-frame gap cycles", 32'(last_long), 32'd20);
        chk(cap == 8'h34, "R2", "second held byte", 32'(cap), 32'h34);
        send(0, 8'h56, 8'h00);
        wait_idle();
        chk(last_hi_run >= 10 && last_hi_run <= 12, "R7", "all-high cycles on switch", 32'(last_hi_run), 32'd10);
        chk(cs_n == 4'b1110, "R6", "new target held", 32'(cs_n), 32'hE);
        bus_wr(3'd1, MODE_BASE);
        send(0, 8'h78, 8'h00);
        wait_idle();
        chk(cs_n == 4'hF, "R5", "release once keep cleared", 32'(cs_n), 32'hF);
        bus_rd(3'd3, v);
    endtask

    task automatic t_cpol();
        logic [31:0] v;
        tb_cpol = 1'b1;
        bus_wr(3'd1, MODE_BASE | 32'h8);
        idle_cycles(2);
        chk(sclk == 1'b1, "R2", "sclk idle with mode bit 3", 32'(sclk), 1);
        send(1, 8'h96, 8'h69);
        wait_idle();
        chk(cap == 8'h96, "R2", "mosi byte inverted clock", 32'(cap), 32'h96);
        bus_rd(3'd3, v);
        chk(v[7:0] == 8'h69, "R2", "rx byte inverted clock", 32'(v[7:0]), 32'h69);
        tb_cpol = 1'b0;
        bus_wr(3'd1, MODE_BASE);
    endtask

    task automatic t_fault();
        logic [31:0] v;
        send(1, 8'hF0, 8'h00);
        idle_cycles(12);
        nss_in = 1'b0;
        idle_cycles(5);
        chk(cs_n == 4'hF, "R9", "cs released on fault", 32'(cs_n), 32'hF);
        chk(sclk == 1'b0, "R9", "sclk idle on fault", 32'(sclk), 0);
        bus_rd(3'd4, v);
        chk(v[4:1] == 4'b0011, "R9", "status busy/en/fault/tx_empty", 32'(v[4:1]), 32'h3);
        bus_rd(3'd4, v);
        chk(v[2] == 1'b0, "R10", "fault cleared by status read", 32'(v[2]), 0);
        nss_in = 1'b1;
        idle_cycles(4);
        send(1, 8'h81, 8'h00);
        idle_cycles(50);
        chk(cs_n == 4'hF, "R10", "no frame while disabled", 32'(cs_n), 32'hF);
        bus_rd(3'd4, v);
        chk(v[3:1] == 3'b000, "R10", "disabled with byte pending", 32'(v[3:1]), 0);
        bus_wr(3'd0, 32'h1);
        wait_idle();
        chk(cap == 8'h81, "R10", "frame after re-enable", 32'(cap), 32'h81);
        bus_rd(3'd3, v);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        bus_wr(3'd1, MODE_BASE | 32'h2);
        nss_in = 1'b0;
        idle_cycles(5);
        send(2, 8'h3C, 8'h00);
        wait_idle();
        chk(cap == 8'h3C, "R11", "frame with detection masked", 32'(cap), 32'h3C);
        bus_rd(3'd4, v);
        chk(v[3:2] == 2'b10, "R11", "no fault when masked", 32'(v[3:2]), 32'h2);
        bus_wr(3'd1, 32'h2);
        bus_wr(3'd1, 32'h0);
        idle_cycles(5);
        bus_rd(3'd4, v);
        chk(v[3:2] == 2'b10, "R11", "no fault outside master mode", 32'(v[3:2]), 32'h2);
        nss_in = 1'b1;
        idle_cycles(4);
        bus_wr(3'd1, MODE_BASE);
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_basic();
        t_hold_gap_switch();
        t_cpol();
        t_fault();
        t_masked();
        idle_cycles(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule